// File: doc/BRIEF.md
# 8-bit ALU with Carry, Zero, Sign and Overflow Flags

This is the purely combinational arithmetic and logic unit of a small 8-bit load/store processor. Each evaluation takes two data operands, a 4-bit operation code and the processor's current flags byte. It returns the 8-bit result and the new flags byte. It also returns one update enable per flag, so the register file can tell which flags the operation defined.

Addition and subtraction share one ripple-carry chain. Subtraction is formed as `a + ~b + 1`, so carry set means no borrow. Shifts move a single bit and report any change of the sign bit in overflow. The rotate takes its distance from the second operand and leaves carry and overflow untouched. Compare and bit test are subtract and AND with the result ignored by the caller. Register writeback and the halt bit belong to the surrounding datapath.

Top module: `alu_czsv`

## Requirements
- R1: With `op_sel` = 1 (add), `result` is `(opa + opb) mod 256`, and flags_out bit 7 (carry) is 1 exactly when the unsigned sum is above 255.
- R2: With `op_sel` = 1, flags_out bit 4 (overflow) is 1 exactly when the sum of the two operands read as signed values lies outside -128..127.
- R3: With `op_sel` = 2 (subtract), `result` is `opa + ~opb + 1` modulo 256. Carry is 1 exactly when `opa >= opb` unsigned. Overflow is 1 exactly when the signed difference lies outside -128..127.
- R4: For every operation that updates them, flags_out bit 6 (zero) is 1 exactly when `result` is 0, and flags_out bit 5 (sign) equals `result[7]`.
- R5: Codes 0 (move, result = `opb`), 3 (AND), 4 (OR) and 5 (XOR) update only zero and sign. Carry and overflow keep their `flags_in` values.
- R6: With `op_sel` = 6, `result` is `opa` rotated right by `opb[2:0]` places, so a distance of 8 acts as 0. Only zero and sign are updated.
- R7: With `op_sel` = 7 (shift left), `result` is `{opa[6:0],0}`, carry is `opa[7]`, and overflow is 1 when bit 7 of the result differs from `opa[7]`.
- R8: With `op_sel` = 8 (shift right), `result` is `{0,opa[7:1]}`, carry is `opa[0]`, and overflow is 1 when bit 7 of the result differs from `opa[7]`.
- R9: flags_out places carry, zero, sign and overflow in bits 7, 6, 5 and 4. Bits 3..0 (halt and three spare bits) equal `flags_in[3:0]`. Any flag not updated equals its `flags_in` bit.
- R10: Codes 9 to 15 give `result` = 0 and update no flag, so flags_out equals flags_in.
- R11: The enables are {upd_c,upd_z,upd_s,upd_v}. They are 1111 for codes 1, 2, 7 and 8, 0110 for codes 0, 3, 4, 5 and 6, and 0000 for codes 9 to 15.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opa | input | 8 | First operand; also the value shifted or rotated |
| opb | input | 8 | Second operand; move source, rotate distance |
| op_sel | input | 4 | Operation code |
| flags_in | input | 8 | Current flags byte |
| result | output | 8 | Operation result |
| flags_out | output | 8 | Next flags byte |
| upd_c | output | 1 | Carry defined by this operation |
| upd_z | output | 1 | Zero defined by this operation |
| upd_s | output | 1 | Sign defined by this operation |
| upd_v | output | 1 | Overflow defined by this operation |

## Verification
The block has no register, so every output is due in the same cycle as its inputs, zero clock edges later. The bench changes inputs on the falling edge and samples a few nanoseconds later, well before the next rising edge, so each check reads fully settled combinational values. The clock only paces the steps. The table walk pairs each input vector with its result, flags byte and enables. A directed sweep then compares add and subtract carries and overflows with values the bench derives from integer arithmetic.

// File: rtl/alu_czsv.sv
module alu_czsv #(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] opa,
  input  logic [DATA_W-1:0] opb,
  input  logic [3:0]        op_sel,
  input  logic [7:0]        flags_in,
  output logic [DATA_W-1:0] result,
  output logic [7:0]        flags_out,
  output logic              upd_c,
  output logic              upd_z,
  output logic              upd_s,
  output logic              upd_v
);
  localparam int SH_W = $clog2(DATA_W);
  localparam int MSB  = DATA_W - 1;
  localparam int C_POS = 7;
  localparam int Z_POS = 6;
  localparam int S_POS = 5;
  localparam int V_POS = 4;

  localparam logic [3:0] OP_MOV = 4'd0;
  localparam logic [3:0] OP_ADD = 4'd1;
  localparam logic [3:0] OP_SUB = 4'd2;
  localparam logic [3:0] OP_AND = 4'd3;
  localparam logic [3:0] OP_OR  = 4'd4;
  localparam logic [3:0] OP_XOR = 4'd5;
  localparam logic [3:0] OP_ROR = 4'd6;
  localparam logic [3:0] OP_SHL = 4'd7;
  localparam logic [3:0] OP_SHR = 4'd8;

  logic              is_sub;
  logic [DATA_W-1:0] b_eff;
  logic [DATA_W-1:0] sum;
  logic              c_msb_in;
  logic              c_out;
  logic [DATA_W-1:0] rot;
  logic              c_new;
  logic              v_new;
  logic              z_new;
  logic              s_new;

  assign is_sub = (op_sel == OP_SUB);
  assign b_eff  = is_sub ? ~opb : opb;

  always_comb begin
    logic cy;
    cy = is_sub;
    c_msb_in = 1'b0;
    for (int i = 0; i < DATA_W; i++) begin
      if (i == MSB) c_msb_in = cy;
      sum[i] = opa[i] ^ b_eff[i] ^ cy;
      cy = (opa[i] & b_eff[i]) | (cy & (opa[i] ^ b_eff[i]));
    end
    c_out = cy;
  end

  always_comb begin
    rot = opa;
    for (int j = 0; j < SH_W; j++) begin
      if (opb[j]) rot = (rot >> (1 << j)) | (rot << (DATA_W - (1 << j)));
    end
  end

  always_comb begin
    result = '0;
    c_new  = 1'b0;
    v_new  = 1'b0;
    {upd_c, upd_z, upd_s, upd_v} = 4'b0000;
    case (op_sel)
      OP_MOV: begin result = opb;       {upd_z, upd_s} = 2'b11; end
      OP_AND: begin result = opa & opb; {upd_z, upd_s} = 2'b11; end
      OP_OR:  begin result = opa | opb; {upd_z, upd_s} = 2'b11; end
      OP_XOR: begin result = opa ^ opb; {upd_z, upd_s} = 2'b11; end
      OP_ROR: begin result = rot;       {upd_z, upd_s} = 2'b11; end
      OP_ADD, OP_SUB: begin
        result = sum;
        c_new  = c_out;
        v_new  = c_out ^ c_msb_in;
        {upd_c, upd_z, upd_s, upd_v} = 4'b1111;
      end
      OP_SHL: begin
        result = {opa[MSB-1:0], 1'b0};
        c_new  = opa[MSB];
        v_new  = opa[MSB] ^ opa[MSB-1];
        {upd_c, upd_z, upd_s, upd_v} = 4'b1111;
      end
      OP_SHR: begin
        result = {1'b0, opa[MSB:1]};
        c_new  = opa[0];
        v_new  = opa[MSB];
        {upd_c, upd_z, upd_s, upd_v} = 4'b1111;
      end
      default: ;
    endcase
  end

  assign z_new = ~|result;
  assign s_new = result[MSB];

  assign flags_out = {upd_c ? c_new : flags_in[C_POS],
                      upd_z ? z_new : flags_in[Z_POS],
                      upd_s ? s_new : flags_in[S_POS],
                      upd_v ? v_new : flags_in[V_POS],
                      flags_in[3:0]};
endmodule

module alu_czsv_chk #(
  parameter int DATA_W = 8
) (
  input logic [DATA_W-1:0] opa,
  input logic [DATA_W-1:0] opb,
  input logic [3:0]        op_sel,
  input logic [7:0]        flags_in,
  input logic [DATA_W-1:0] result,
  input logic [7:0]        flags_out,
  input logic              upd_c,
  input logic              upd_z,
  input logic              upd_s,
  input logic              upd_v
);
  always_comb begin
    assert_tail_pass_R9: assert (flags_out[3:0] == flags_in[3:0]);
    if (!upd_c) assert_keep_c_R9: assert (flags_out[7] == flags_in[7]);
    if (!upd_v) assert_keep_v_R9: assert (flags_out[4] == flags_in[4]);
    if (upd_z) assert_zero_R4: assert (flags_out[6] == (result == '0));
    if (upd_s) assert_sign_R4: assert (flags_out[5] == result[DATA_W-1]);
    if (op_sel == 4'd1)
      assert_add_sum_R1: assert ({flags_out[7], result} == ({1'b0, opa} + {1'b0, opb}));
    if (op_sel == 4'd2)
      assert_sub_carry_R3: assert (flags_out[7] == (opa >= opb));
    if (op_sel == 4'd6)
      assert_ror_keep_R6: assert (!upd_c && !upd_v && upd_z && upd_s);
    if (op_sel > 4'd8)
      assert_idle_code_R10: assert (result == '0 && flags_out == flags_in);
  end
endmodule

bind alu_czsv alu_czsv_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/sim_alu_czsv.sv
module sim_alu_czsv;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0] opa, opb, flags_in, result, flags_out;
  logic [3:0] op_sel;
  logic upd_c, upd_z, upd_s, upd_v;
  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  alu_czsv #(.DATA_W(8)) u0 (
    .opa(opa), .opb(opb), .op_sel(op_sel), .flags_in(flags_in),
    .result(result), .flags_out(flags_out),
    .upd_c(upd_c), .upd_z(upd_z), .upd_s(upd_s), .upd_v(upd_v)
  );

  typedef struct packed {
    logic [7:0] tag;
    logic [3:0] op;
    logic [7:0] a;
    logic [7:0] b;
    logic [7:0] fi;
    logic [7:0] res;
    logic [7:0] fo;
    logic [3:0] upd;
  } vec_t;

  localparam int NV = 26;
  localparam vec_t VECS [NV] = '{
    {8'd5,  4'd0, 8'h12, 8'h6E, 8'h00, 8'h6E, 8'h00, 4'b0110}, // R5 move
    {8'd5,  4'd0, 8'h12, 8'h80, 8'h90, 8'h80, 8'hB0, 4'b0110}, // R5 move keeps C,V
    {8'd2,  4'd1, 8'h7F, 8'h01, 8'h00, 8'h80, 8'h30, 4'b1111}, // R2 signed overflow
    {8'd1,  4'd1, 8'hFF, 8'h01, 8'h00, 8'h00, 8'hC0, 4'b1111}, // R1 carry out
    {8'd2,  4'd1, 8'h80, 8'h80, 8'h00, 8'h00, 8'hD0, 4'b1111}, // R2 negative overflow
    {8'd9,  4'd1, 8'h10, 8'h20, 8'hF8, 8'h30, 8'h08, 4'b1111}, // R9 H kept
    {8'd3,  4'd2, 8'h05, 8'h03, 8'h00, 8'h02, 8'h80, 4'b1111}, // R3 no borrow
    {8'd3,  4'd2, 8'h03, 8'h05, 8'h00, 8'hFE, 8'h20, 4'b1111}, // R3 borrow
    {8'd3,  4'd2, 8'h80, 8'h01, 8'h00, 8'h7F, 8'h90, 4'b1111}, // R3 overflow
    {8'd3,  4'd2, 8'h42, 8'h42, 8'h00, 8'h00, 8'hC0, 4'b1111}, // R3 equal
    {8'd3,  4'd2, 8'h7F, 8'hFF, 8'h00, 8'h80, 8'h30, 4'b1111}, // R3 127-(-1)
    {8'd5,  4'd3, 8'hF0, 8'h0F, 8'h90, 8'h00, 8'hD0, 4'b0110}, // R5 and
    {8'd5,  4'd4, 8'h80, 8'h01, 8'h00, 8'h81, 8'h20, 4'b0110}, // R5 or
    {8'd5,  4'd5, 8'hAA, 8'hAA, 8'h00, 8'h00, 8'h40, 4'b0110}, // R5 xor
    {8'd6,  4'd6, 8'h01, 8'h01, 8'h90, 8'h80, 8'hB0, 4'b0110}, // R6 keeps C,V
    {8'd6,  4'd6, 8'h96, 8'h03, 8'h00, 8'hD2, 8'h20, 4'b0110}, // R6 by 3
    {8'd6,  4'd6, 8'h5A, 8'h08, 8'h00, 8'h5A, 8'h00, 4'b0110}, // R6 by 8 = 0
    {8'd6,  4'd6, 8'h5A, 8'h0B, 8'h00, 8'h4B, 8'h00, 4'b0110}, // R6 by 11 = 3
    {8'd7,  4'd7, 8'h81, 8'h00, 8'h00, 8'h02, 8'h90, 4'b1111}, // R7
    {8'd7,  4'd7, 8'h40, 8'h00, 8'h00, 8'h80, 8'h30, 4'b1111}, // R7 sign flip
    {8'd7,  4'd7, 8'h80, 8'h00, 8'h00, 8'h00, 8'hD0, 4'b1111}, // R7 to zero
    {8'd8,  4'd8, 8'h01, 8'h00, 8'h00, 8'h00, 8'hC0, 4'b1111}, // R8 to zero
    {8'd8,  4'd8, 8'h81, 8'h00, 8'h00, 8'h40, 8'h90, 4'b1111}, // R8 sign flip
    {8'd8,  4'd8, 8'h02, 8'h00, 8'hFF, 8'h01, 8'h0F, 4'b1111}, // R8 clears CZSV
    {8'd10, 4'd15, 8'h55, 8'h33, 8'hA5, 8'h00, 8'hA5, 4'b0000}, // R10
    {8'd4,  4'd0, 8'h99, 8'h00, 8'h07, 8'h00, 8'h47, 4'b0110}  // R4 zero on move
  };

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [3:0] o, input logic [7:0] a, input logic [7:0] b,
                       input logic [7:0] f);
    @(negedge clk);
    op_sel = o; opa = a; opb = b; flags_in = f;
    #3;
  endtask

  initial begin
    #(20 * 200000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    op_sel = 4'd0; opa = 8'h00; opb = 8'h00; flags_in = 8'h00;
    repeat (3) @(posedge clk);
    @(negedge clk); #3;
    chk("R4 reset result", result, 8'h00);
    chk("R4 reset flags", flags_out, 8'h40);
    chk("R11 reset enables", {upd_c, upd_z, upd_s, upd_v}, 4'b0110);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      vec_t v;
      string tg;
      v = VECS[i];
      tg = $sformatf("R%0d vec%0d", v.tag, i);
      drive(v.op, v.a, v.b, v.fi);
      chk({tg, " result"}, result, v.res);
      chk({tg, " flags"}, flags_out, v.fo);
      chk({"R11 ", tg, " enables"}, {upd_c, upd_z, upd_s, upd_v}, v.upd);
    end

    for (int a = 0; a < 256; a += 17) begin
      for (int b = 0; b < 256; b += 13) begin
        int sa, sb;
        sa = (a > 127) ? a - 256 : a;
        sb = (b > 127) ? b - 256 : b;
        drive(4'd1, a[7:0], b[7:0], 8'h00);
        chk("R1 sweep sum", result, (a + b) % 256);
        chk("R1 sweep carry", flags_out[7], (a + b > 255) ? 1 : 0);
        chk("R2 sweep overflow", flags_out[4], (sa + sb > 127 || sa + sb < -128) ? 1 : 0);
        drive(4'd2, a[7:0], b[7:0], 8'h00);
        chk("R3 sweep diff", result, (a - b + 256) % 256);
        chk("R3 sweep carry", flags_out[7], (a >= b) ? 1 : 0);
        chk("R3 sweep overflow", flags_out[4], (sa - sb > 127 || sa - sb < -128) ? 1 : 0);
      end
    end

    for (int k = 9; k < 16; k++) begin
      drive(k[3:0], 8'hC3, 8'h3C, 8'h5A);
      chk("R10 idle result", result, 8'h00);
      chk("R10 idle flags", flags_out, 8'h5A);
    end

    for (int d = 0; d < 16; d++) begin
      logic [7:0] e;
      int s;
      s = d % 8;
      e = (s == 0) ? 8'hB1 : 8'((8'hB1 >> s) | (8'hB1 << (8 - s)));
      drive(4'd6, 8'hB1, d[7:0], 8'h90);
      chk("R6 rotate sweep", result, e);
      chk("R6 rotate keeps C,V", {flags_out[7], flags_out[4]}, 2'b11);
    end

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule